// File: doc/BRIEF.md
# Two-Die Package Idle State Coordinator

This block sits on each die of a package built from two dual-core dies that share one core supply rail. Each die reduces the idle requests of its own cores to a single local state and reports that state and a ready flag to the other die. A strap input tells the instance whether it is the master or the secondary. Only the master turns the two dies' reports into a package idle state and requests it from the platform (and through it the rail regulator); the secondary only reports.

Idle states are coded as unsigned numbers: 0 means running, and a larger value means a deeper idle state. The package state is the shallowest state any core asked for, and it is used only while both dies report ready. The dies run on independent clocks, so the peer's ready flag passes through a synchronizer before it is used. The peer must hold its reported state steady while its ready flag is high. A change of the package state goes to the platform as a request held until the platform acknowledges it, and the committed package state follows that acknowledge.

Top module: `die_idle_coord`

## Requirements
- R1: One cycle after the core requests are sampled, `loc_state_o` equals the smallest of the per-core requested states. Core i's request sits in bits [i*ST_W +: ST_W] of `core_req_i`.
- R2: `loc_ready_o` is high exactly when every local core requests a nonzero (idle) state. It follows the requests with the same one-cycle latency as R1.
- R3: The master asserts `plat_req_o` toward an idle state only while both its own ready and the synchronized peer ready are high. The requested state is then the smaller of the local and peer states.
- R4: While `plat_req_o` is high and `plat_ack_i` is low, `plat_req_o` stays high and `plat_state_o` holds its value.
- R5: `pkg_state_o` changes only on the cycle after a cycle with both `plat_req_o` and `plat_ack_i` high, and it then takes the requested state.
- R6: If either die drops its ready flag while the committed package state is nonzero, the master requests package state 0.
- R7: With the strap low (secondary), `plat_req_o` is never asserted and `pkg_state_o` stays 0.
- R8: During reset, all outputs are 0.
- R9: A new request is raised only when the target state differs from the committed package state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Die clock |
| rst_n | input | 1 | Active-low synchronous reset |
| is_master_i | input | 1 | Strap: 1 = master die, 0 = secondary die |
| core_req_i | input | NUM_CORES*ST_W | Per-core requested idle states |
| peer_state_i | input | ST_W | Local state reported by the other die |
| peer_ready_i | input | 1 | Ready flag from the other die (asynchronous) |
| loc_state_o | output | ST_W | Resolved local state sent to the other die |
| loc_ready_o | output | 1 | Local ready flag sent to the other die |
| plat_req_o | output | 1 | Package state change request to the platform |
| plat_state_o | output | ST_W | State carried by the pending request |
| plat_ack_i | input | 1 | Platform acknowledge of the request |
| pkg_state_o | output | ST_W | Committed package idle state |

## Verification
The bound checker watches the handshake rules on every cycle. It checks that a request holds steady until it is acknowledged, that the committed state moves only after an acknowledge, that each new request differs from the committed state, that the secondary stays silent, and that the local state never exceeds any core's request. Only the bench scenarios can show the end-to-end decisions. These are the choice of the shallower of the two dies' states, waiting for the synchronized peer ready, and the exit to state 0 after a wake on either die. Each of these needs a particular ordering of requests, peer flags and acknowledges.

// File: rtl/idlec_pkg.sv
package idlec_pkg;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_REQ  = 1'b1
    } phase_e;

endpackage

// File: rtl/idlec_min.sv
module idlec_min #(
    parameter int NUM_CORES = 2,
    parameter int ST_W      = 3
) (
    input  logic [NUM_CORES*ST_W-1:0] req_i,
    output logic [ST_W-1:0]           min_o
);
    always_comb begin
        min_o = req_i[ST_W-1:0];
        for (int i = 1; i < NUM_CORES; i++) begin
            if (req_i[i*ST_W +: ST_W] < min_o) begin
                min_o = req_i[i*ST_W +: ST_W];
            end
        end
    end
endmodule

// File: rtl/idlec_sync.sv
module idlec_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    generate
        if (STAGES <= 1) begin : g_one
            logic r_q;
            always_ff @(posedge clk) begin
                if (!rst_n) r_q <= 1'b0;
                else        r_q <= d_i;
            end
            assign q_o = r_q;
        end else begin : g_chain
            logic [STAGES-1:0] chain_q;
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], d_i};
            end
            assign q_o = chain_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/die_idle_coord.sv
module die_idle_coord
    import idlec_pkg::*;
#(
    parameter int NUM_CORES   = 2,
    parameter int ST_W        = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      is_master_i,
    input  logic [NUM_CORES*ST_W-1:0] core_req_i,
    input  logic [ST_W-1:0]           peer_state_i,
    input  logic                      peer_ready_i,
    output logic [ST_W-1:0]           loc_state_o,
    output logic                      loc_ready_o,
    output logic                      plat_req_o,
    output logic [ST_W-1:0]           plat_state_o,
    input  logic                      plat_ack_i,
    output logic [ST_W-1:0]           pkg_state_o
);
    localparam logic [ST_W-1:0] ST_RUN = '0;

    typedef struct packed {
        logic [ST_W-1:0] loc_state;
        logic            loc_ready;
        phase_e          phase;
        logic [ST_W-1:0] req_state;
        logic [ST_W-1:0] pkg_state;
    } coord_t;

    coord_t          st_d, st_q;
    logic [ST_W-1:0] loc_min;
    logic            peer_rdy_s;
    logic [ST_W-1:0] target;

    idlec_min #(.NUM_CORES(NUM_CORES), .ST_W(ST_W)) u_min (
        .req_i (core_req_i),
        .min_o (loc_min)
    );

    idlec_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (peer_ready_i),
        .q_o   (peer_rdy_s)
    );

    always_comb begin
        st_d           = st_q;
        st_d.loc_state = loc_min;
        st_d.loc_ready = (loc_min != ST_RUN);

        if (st_q.loc_ready && peer_rdy_s) begin
            target = (peer_state_i < st_q.loc_state) ? peer_state_i : st_q.loc_state;
        end else begin
            target = ST_RUN;
        end

        if (!is_master_i) begin
            st_d.phase     = PH_IDLE;
            st_d.req_state = ST_RUN;
            st_d.pkg_state = ST_RUN;
        end else begin
            case (st_q.phase)
                PH_IDLE: begin
                    if (target != st_q.pkg_state) begin
                        st_d.phase     = PH_REQ;
                        st_d.req_state = target;
                    end
                end
                PH_REQ: begin
                    if (plat_ack_i) begin
                        st_d.pkg_state = st_q.req_state;
                        st_d.phase     = PH_IDLE;
                    end
                end
                default: st_d.phase = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{loc_state: ST_RUN, loc_ready: 1'b0, phase: PH_IDLE,
                      req_state: ST_RUN, pkg_state: ST_RUN};
        end else begin
            st_q <= st_d;
        end
    end

    assign loc_state_o  = st_q.loc_state;
    assign loc_ready_o  = st_q.loc_ready;
    assign plat_req_o   = (st_q.phase == PH_REQ);
    assign plat_state_o = st_q.req_state;
    assign pkg_state_o  = st_q.pkg_state;
endmodule

// File: rtl/idlec_checker.sv
module idlec_checker #(
    parameter int NUM_CORES = 2,
    parameter int ST_W      = 3
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      is_master_i,
    input logic [NUM_CORES*ST_W-1:0] core_req_i,
    input logic [ST_W-1:0]           loc_state_o,
    input logic                      plat_req_o,
    input logic [ST_W-1:0]           plat_state_o,
    input logic                      plat_ack_i,
    input logic [ST_W-1:0]           pkg_state_o
);
    genvar gi;
    generate
        for (gi = 0; gi < NUM_CORES; gi++) begin : g_core
            a_r1_not_deeper: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> loc_state_o <= $past(core_req_i[gi*ST_W +: ST_W]));
        end
    endgenerate

    a_r4_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        plat_req_o && !plat_ack_i |=> plat_req_o && $stable(plat_state_o));

    a_r5_commit_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && (pkg_state_o != $past(pkg_state_o)) |->
            $past(plat_req_o && plat_ack_i) && (pkg_state_o == $past(plat_state_o)));

    a_r7_secondary_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !is_master_i && $past(!is_master_i) |-> !plat_req_o && pkg_state_o == '0);

    a_r9_req_is_change: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(plat_req_o) |-> plat_state_o != pkg_state_o);
endmodule

bind die_idle_coord idlec_checker #(.NUM_CORES(NUM_CORES), .ST_W(ST_W)) u_idlec_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .is_master_i  (is_master_i),
    .core_req_i   (core_req_i),
    .loc_state_o  (loc_state_o),
    .plat_req_o   (plat_req_o),
    .plat_state_o (plat_state_o),
    .plat_ack_i   (plat_ack_i),
    .pkg_state_o  (pkg_state_o)
);

// File: tb/die_idle_coord_bench.sv
module die_idle_coord_bench;
    localparam int NC = 2;
    localparam int SW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          is_master_i = 1'b1;
    logic [NC*SW-1:0] core_req_i = '0;
    logic [SW-1:0] peer_state_i = '0;
    logic          peer_ready_i = 1'b0;
    logic [SW-1:0] loc_state_o;
    logic          loc_ready_o;
    logic          plat_req_o;
    logic [SW-1:0] plat_state_o;
    logic          plat_ack_i = 1'b0;
    logic [SW-1:0] pkg_state_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    die_idle_coord #(.NUM_CORES(NC), .ST_W(SW), .SYNC_STAGES(2)) u_die_idle_coord (
        .clk(clk), .rst_n(rst_n), .is_master_i(is_master_i), .core_req_i(core_req_i),
        .peer_state_i(peer_state_i), .peer_ready_i(peer_ready_i),
        .loc_state_o(loc_state_o), .loc_ready_o(loc_ready_o),
        .plat_req_o(plat_req_o), .plat_state_o(plat_state_o),
        .plat_ack_i(plat_ack_i), .pkg_state_o(pkg_state_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic set_cores(input int a, input int b);
        core_req_i = {SW'(b), SW'(a)};
    endtask

    task automatic wait_req(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 20; i++) begin
            if (plat_req_o) begin seen = 1'b1; break; end
            step(1);
        end
    endtask

    task automatic ack_once;
        plat_ack_i = 1'b1;
        step(1);
        plat_ack_i = 1'b0;
    endtask

    task automatic do_reset(input bit master);
        rst_n = 1'b0; is_master_i = master; plat_ack_i = 1'b0;
        set_cores(0, 0); peer_ready_i = 1'b0; peer_state_i = '0;
        step(3);
        check("R8 loc_state", loc_state_o, 0);
        check("R8 loc_ready", loc_ready_o, 0);
        check("R8 plat_req", plat_req_o, 0);
        check("R8 pkg_state", pkg_state_o, 0);
        rst_n = 1'b1;
        step(1);
    endtask

    task automatic t_local;
        set_cores(3, 5);
        step(1);
        check("R1 min of 3,5", loc_state_o, 3);
        check("R2 ready all idle", loc_ready_o, 1);
        set_cores(6, 2);
        step(1);
        check("R1 min of 6,2", loc_state_o, 2);
        set_cores(4, 0);
        step(1);
        check("R1 min with running core", loc_state_o, 0);
        check("R2 not ready one running", loc_ready_o, 0);
    endtask

    task automatic t_enter;
        bit seen;
        set_cores(3, 5);
        peer_state_i = 3'd2; peer_ready_i = 1'b0;
        step(10);
        check("R3 no req without peer ready", plat_req_o, 0);
        peer_ready_i = 1'b1;
        wait_req(seen);
        check("R3 req raised both ready", seen, 1);
        check("R3 req state min(3,2)", plat_state_o, 2);
        step(5);
        check("R4 req held", plat_req_o, 1);
        check("R4 state held", plat_state_o, 2);
        check("R5 pkg unchanged before ack", pkg_state_o, 0);
        ack_once;
        check("R5 pkg after ack", pkg_state_o, 2);
        check("R5 req dropped", plat_req_o, 0);
        step(10);
        check("R9 no req when target equal", plat_req_o, 0);
    endtask

    task automatic t_local_wake;
        bit seen;
        set_cores(0, 5);
        wait_req(seen);
        check("R6 local wake req", seen, 1);
        check("R6 local wake state", plat_state_o, 0);
        ack_once;
        check("R6 pkg back to run", pkg_state_o, 0);
    endtask

    task automatic t_peer_wake;
        bit seen;
        set_cores(4, 6); peer_state_i = 3'd7; peer_ready_i = 1'b1;
        wait_req(seen);
        check("R3 req state min(4,7)", plat_state_o, 4);
        ack_once;
        check("R5 pkg 4", pkg_state_o, 4);
        peer_ready_i = 1'b0;
        wait_req(seen);
        check("R6 peer wake req", seen, 1);
        check("R6 peer wake state", plat_state_o, 0);
        ack_once;
        check("R6 pkg run after peer wake", pkg_state_o, 0);
    endtask

    task automatic t_secondary;
        do_reset(1'b0);
        set_cores(5, 5); peer_state_i = 3'd5; peer_ready_i = 1'b1;
        step(20);
        check("R7 secondary no req", plat_req_o, 0);
        check("R7 secondary pkg", pkg_state_o, 0);
        check("R2 secondary still reports ready", loc_ready_o, 1);
        check("R1 secondary still reports state", loc_state_o, 5);
    endtask

    initial begin
        do_reset(1'b1);
        t_local;
        t_enter;
        t_local_wake;
        t_peer_wake;
        t_secondary;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000 && !done) begin
            fails = fails + 1;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule